// File: doc/BRIEF.md
# Control Endpoint OUT Receive and Stall Logic

This block handles the receive side of a control endpoint during the data stage of an OUT control transfer. It sits between a USB packet engine and a CPU register interface. The packet engine delivers the bytes of each OUT data packet one at a time and then gives an end-of-packet strobe with the byte count. The block decides the handshake for that packet (ACK, NAK or STALL), stores accepted bytes in a small linear receive buffer, and raises a ready flag when the CPU should unload the buffer.

The CPU reads the buffer one byte at a time. It clears the ready flag to empty the buffer and release it for more packets. When the CPU has taken the whole expected data stage, it sets a data-end flag. From then on, any further OUT data from the host is stalled by hardware. Before data-end is set, surplus packets are still acknowledged, so the CPU must spot an over-long transfer itself and write the send-stall bit. A new SETUP packet or a bus reset clears data-end, send-stall, the ready flag and the buffer.

Top module: `ctrl_out_stall`

## Requirements
- R1: After `rst`, `out_rdy`, `data_end`, `stall_on` and `hs_valid` are 0, `hs_code` is 00 and `fill` is 0.
- R2: A packet that is accepted is answered with `hs_code` = 01 (ACK), with `hs_valid` high for exactly the cycle after the `rx_end` strobe. Its `rx_len` bytes are appended to the buffer and `fill` grows by `rx_len`.
- R3: An accepted packet with `rx_len` < `maxp` (a short packet, including zero length) sets `out_rdy`. A full-size packet leaves `out_rdy` clear while the buffer still has room for another full packet.
- R4: An accepted packet that leaves less than `maxp` bytes free in the `BUF_BYTES` buffer sets `out_rdy`. `fill` never exceeds `BUF_BYTES`.
- R5: While `out_rdy` is 1 and neither stall condition holds, a new packet is answered with `hs_code` = 10 (NAK) and nothing is stored (`fill` is unchanged).
- R6: `cpu_data` shows the stored bytes in arrival order, and each `cpu_rd` pulse advances to the next byte. A `cpu_clr_rdy` pulse while `out_rdy` is 1 clears `out_rdy` and empties the buffer (`fill` = 0).
- R7: A `cpu_set_dend` pulse sets `data_end`. While `data_end` is 1, every OUT packet is answered with `hs_code` = 11 (STALL) and is not stored. While it is 0, packets beyond the expected transfer length are still acknowledged.
- R8: A `cpu_set_stall` pulse sets `stall_on`. While `stall_on` is 1, every packet is answered with STALL, and this takes precedence over NAK.
- R9: A `setup_rx` or `usb_reset` pulse clears `data_end`, `stall_on` and `out_rdy`, and empties the buffer.
- R10: Whenever `hs_valid` is 0, `hs_code` is 00. The handshake is chosen from the flag values held before the `rx_end` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_reset | input | 1 | Bus reset seen, one-cycle pulse |
| setup_rx | input | 1 | New SETUP packet seen, one-cycle pulse |
| maxp | input | CNT_W | Max packet size of the endpoint, 1..BUF_BYTES |
| rx_wr | input | 1 | Data byte of the current OUT packet is valid |
| rx_byte | input | 8 | Data byte of the current OUT packet |
| rx_end | input | 1 | End-of-packet strobe |
| rx_len | input | CNT_W | Byte count of the ending packet, at most maxp |
| cpu_rd | input | 1 | CPU pops one byte from the buffer |
| cpu_data | output | 8 | Byte at the CPU read position |
| cpu_clr_rdy | input | 1 | CPU clears the ready flag and empties the buffer |
| cpu_set_dend | input | 1 | CPU sets the data-end flag |
| cpu_set_stall | input | 1 | CPU forces STALL |
| out_rdy | output | 1 | Buffer ready for the CPU to unload |
| data_end | output | 1 | Data-end flag |
| stall_on | output | 1 | Forced-stall flag |
| fill | output | CNT_W | Bytes stored in the buffer |
| hs_valid | output | 1 | Handshake code valid this cycle |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |

## Verification
The hardest state to reach is a full buffer reached through full-size packets only, where the ready flag has to rise because no room remains for another packet rather than because a short packet arrived. The stimulus table reaches it by clearing a ready buffer and then streaming four maximum-size packets into it. A NAK probe follows to confirm that no more data is taken. A second hard case is a stall request that meets a buffer that is still ready. A directed test leaves the buffer ready after a byte-by-byte readback, sets the stall, and checks that STALL wins over NAK with the buffer left untouched.

// File: rtl/cep_pkg.sv
package cep_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_code_e;

    typedef struct packed {
        logic clr_rdy;
        logic set_dend;
        logic set_stall;
    } cpu_wr_t;

    typedef struct packed {
        logic stall_on;
        logic data_end;
        logic out_rdy;
    } ep_flags_t;

    // Handshake priority: forced stall / data end, then busy buffer, then accept.
    function automatic hs_code_e pick_hs(input ep_flags_t f);
        if (f.stall_on || f.data_end) return HS_STALL;
        if (f.out_rdy)                return HS_NAK;
        return HS_ACK;
    endfunction

    // The CPU must unload after a short packet or when a full packet no longer fits.
    function automatic logic want_unload(input logic [31:0] len,
                                         input logic [31:0] fill_after,
                                         input logic [31:0] mps,
                                         input logic [31:0] buf_bytes);
        return (len < mps) || ((fill_after + mps) > buf_bytes);
    endfunction

endpackage

// File: rtl/cep_rx_buf.sv
module cep_rx_buf
    import cep_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 32,
    parameter int unsigned CNT_W     = $clog2(BUF_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              end_pkt,
    input  logic              commit,
    input  logic [CNT_W-1:0]  commit_len,
    input  logic              rd,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill
);
    localparam int unsigned AW = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;
    localparam logic [CNT_W-1:0] DEPTH = CNT_W'(BUF_BYTES);

    logic [BYTE_W-1:0] mem [BUF_BYTES];
    logic [CNT_W-1:0]  pend;
    logic [CNT_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  wr_idx;
    logic              wr_ok;

    assign wr_idx  = fill + pend;
    assign wr_ok   = wr && (wr_idx < DEPTH);
    assign rd_data = mem[rd_ptr[AW-1:0]];

    // Bytes land after the committed data; they count only once the packet is ACKed.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_idx[AW-1:0]] <= wr_byte;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            pend   <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (end_pkt)      pend <= '0;
            else if (wr_ok)   pend <= pend + CNT_W'(1);
            if (commit)       fill <= fill + commit_len;
            if (rd && (rd_ptr < fill)) rd_ptr <= rd_ptr + CNT_W'(1);
        end
    end

    p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
        fill <= DEPTH);

    p_rd_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        rd_ptr <= fill);

endmodule

// File: rtl/cep_hs_ctrl.sv
module cep_hs_ctrl
    import cep_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 32,
    parameter int unsigned CNT_W     = $clog2(BUF_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             usb_reset,
    input  logic             setup_rx,
    input  cpu_wr_t          cpu,
    input  logic             rx_end,
    input  logic [CNT_W-1:0] rx_len,
    input  logic [CNT_W-1:0] maxp,
    input  logic [CNT_W-1:0] fill,
    output ep_flags_t        flags,
    output logic             commit,
    output logic             flush,
    output logic             hs_valid,
    output hs_code_e         hs_code
);
    hs_code_e    decision;
    logic        clear_all;
    logic        unload;
    logic [31:0] fill_after;

    assign decision   = pick_hs(flags);
    assign clear_all  = usb_reset || setup_rx;
    assign commit     = rx_end && (decision == HS_ACK) && !clear_all;
    assign flush      = clear_all || (cpu.clr_rdy && flags.out_rdy);
    assign fill_after = 32'(fill) + 32'(rx_len);
    assign unload     = want_unload(32'(rx_len), fill_after, 32'(maxp), 32'(BUF_BYTES));

    always_ff @(posedge clk) begin
        if (rst || clear_all) begin
            flags <= '0;
        end else begin
            if (cpu.set_dend)  flags.data_end <= 1'b1;
            if (cpu.set_stall) flags.stall_on <= 1'b1;
            if (cpu.clr_rdy)   flags.out_rdy  <= 1'b0;
            if (commit && unload) flags.out_rdy <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
        end else begin
            hs_valid <= rx_end;
            hs_code  <= rx_end ? decision : HS_NONE;
        end
    end

    p_dend_stalls_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_end && flags.data_end) |=> (hs_valid && hs_code == HS_STALL));

    p_forced_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_end && flags.stall_on) |=> (hs_code == HS_STALL));

    p_short_sets_rdy_r3: assert property (@(posedge clk) disable iff (rst)
        (commit && (rx_len < maxp)) |=> flags.out_rdy);

    p_setup_clears_r9: assert property (@(posedge clk) disable iff (rst)
        clear_all |=> (!flags.data_end && !flags.stall_on && !flags.out_rdy));

    p_idle_code_r10: assert property (@(posedge clk) disable iff (rst)
        !hs_valid |-> (hs_code == HS_NONE));

endmodule

// File: rtl/ctrl_out_stall.sv
module ctrl_out_stall
    import cep_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 32,
    parameter int unsigned CNT_W     = $clog2(BUF_BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             usb_reset,
    input  logic             setup_rx,
    input  logic [CNT_W-1:0] maxp,
    input  logic             rx_wr,
    input  logic [7:0]       rx_byte,
    input  logic             rx_end,
    input  logic [CNT_W-1:0] rx_len,
    input  logic             cpu_rd,
    output logic [7:0]       cpu_data,
    input  logic             cpu_clr_rdy,
    input  logic             cpu_set_dend,
    input  logic             cpu_set_stall,
    output logic             out_rdy,
    output logic             data_end,
    output logic             stall_on,
    output logic [CNT_W-1:0] fill,
    output logic             hs_valid,
    output logic [1:0]       hs_code
);
    cpu_wr_t   cpu_w;
    ep_flags_t flags;
    logic      commit;
    logic      flush;
    hs_code_e  code_int;

    assign cpu_w = '{clr_rdy: cpu_clr_rdy, set_dend: cpu_set_dend, set_stall: cpu_set_stall};

    cep_hs_ctrl #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .usb_reset (usb_reset),
        .setup_rx  (setup_rx),
        .cpu       (cpu_w),
        .rx_end    (rx_end),
        .rx_len    (rx_len),
        .maxp      (maxp),
        .fill      (fill),
        .flags     (flags),
        .commit    (commit),
        .flush     (flush),
        .hs_valid  (hs_valid),
        .hs_code   (code_int)
    );

    cep_rx_buf #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .wr         (rx_wr),
        .wr_byte    (rx_byte),
        .end_pkt    (rx_end),
        .commit     (commit),
        .commit_len (rx_len),
        .rd         (cpu_rd),
        .rd_data    (cpu_data),
        .fill       (fill)
    );

    assign out_rdy  = flags.out_rdy;
    assign data_end = flags.data_end;
    assign stall_on = flags.stall_on;
    assign hs_code  = code_int;

    p_nak_keeps_fill_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_end && out_rdy && !stall_on && !data_end && !cpu_clr_rdy && !setup_rx && !usb_reset)
        |=> (hs_code == 2'b10 && fill == $past(fill)));

    p_ack_grows_fill_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_end && !out_rdy && !stall_on && !data_end && !setup_rx && !usb_reset)
        |=> (hs_code == 2'b01 && fill == $past(fill) + $past(rx_len)));

endmodule

// File: tb/ctrl_out_stall_bench.sv
module ctrl_out_stall_bench;
    localparam int unsigned BUF_BYTES = 32;
    localparam int unsigned CW = $clog2(BUF_BYTES) + 1;
    localparam logic [1:0] C_NONE = 2'b00, C_ACK = 2'b01, C_NAK = 2'b10, C_STALL = 2'b11;
    // actions: 0 none, 1 clear ready, 2 set data end, 3 set stall, 4 setup, 5 clear ready + data end
    typedef struct packed {
        logic [2:0]    act;
        logic [CW-1:0] len;
        logic [1:0]    code;
        logic          rdy;
        logic [CW-1:0] fill;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 6'd8, 2'b01, 1'b0, 6'd8 },
        '{3'd0, 6'd8, 2'b01, 1'b0, 6'd16},
        '{3'd0, 6'd8, 2'b01, 1'b0, 6'd24},
        '{3'd0, 6'd2, 2'b01, 1'b1, 6'd26},
        '{3'd0, 6'd8, 2'b10, 1'b1, 6'd26},
        '{3'd1, 6'd8, 2'b01, 1'b0, 6'd8 },
        '{3'd0, 6'd8, 2'b01, 1'b0, 6'd16},
        '{3'd0, 6'd8, 2'b01, 1'b0, 6'd24},
        '{3'd0, 6'd8, 2'b01, 1'b1, 6'd32},
        '{3'd0, 6'd4, 2'b10, 1'b1, 6'd32},
        '{3'd5, 6'd8, 2'b11, 1'b0, 6'd0 },
        '{3'd0, 6'd2, 2'b11, 1'b0, 6'd0 },
        '{3'd4, 6'd8, 2'b01, 1'b0, 6'd8 },
        '{3'd3, 6'd3, 2'b11, 1'b0, 6'd8 },
        '{3'd4, 6'd0, 2'b01, 1'b1, 6'd0 }
    };

    logic clk = 1'b0;
    logic rst, usb_reset, setup_rx, rx_wr, rx_end, cpu_rd;
    logic cpu_clr_rdy, cpu_set_dend, cpu_set_stall;
    logic [CW-1:0] maxp, rx_len, fill;
    logic [7:0] rx_byte, cpu_data;
    logic out_rdy, data_end, stall_on, hs_valid;
    logic [1:0] hs_code;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ctrl_out_stall #(.BUF_BYTES(BUF_BYTES)) u_ctrl_out_stall (
        .clk(clk), .rst(rst), .usb_reset(usb_reset), .setup_rx(setup_rx), .maxp(maxp),
        .rx_wr(rx_wr), .rx_byte(rx_byte), .rx_end(rx_end), .rx_len(rx_len),
        .cpu_rd(cpu_rd), .cpu_data(cpu_data), .cpu_clr_rdy(cpu_clr_rdy),
        .cpu_set_dend(cpu_set_dend), .cpu_set_stall(cpu_set_stall),
        .out_rdy(out_rdy), .data_end(data_end), .stall_on(stall_on), .fill(fill),
        .hs_valid(hs_valid), .hs_code(hs_code)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic send_pkt(input int len, input logic [7:0] base);
        for (int i = 0; i < len; i++) begin
            rx_wr = 1'b1; rx_byte = base + 8'(i);
            @(negedge clk);
        end
        rx_wr = 1'b0; rx_end = 1'b1; rx_len = CW'(len);
        @(negedge clk);
        rx_end = 1'b0;
    endtask

    task automatic cpu_act(input logic [2:0] a);
        if (a == 3'd0) return;
        cpu_clr_rdy   = (a == 3'd1) || (a == 3'd5);
        cpu_set_dend  = (a == 3'd2) || (a == 3'd5);
        cpu_set_stall = (a == 3'd3);
        setup_rx      = (a == 3'd4);
        @(negedge clk);
        cpu_clr_rdy = 1'b0; cpu_set_dend = 1'b0; cpu_set_stall = 1'b0; setup_rx = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; usb_reset = 1'b0; setup_rx = 1'b0; rx_wr = 1'b0; rx_end = 1'b0;
        cpu_rd = 1'b0; cpu_clr_rdy = 1'b0; cpu_set_dend = 1'b0; cpu_set_stall = 1'b0;
        maxp = CW'(8); rx_len = '0; rx_byte = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 flags", {29'd0, out_rdy, data_end, stall_on}, 32'd0);
        chk("R1 fill", 32'(fill), 32'd0);
        chk("R1 handshake", {29'd0, hs_valid, hs_code}, 32'd0);

        // Table walk: R2 R3 R4 R5 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            cpu_act(VEC[k].act);
            send_pkt(int'(VEC[k].len), 8'(k * 16));
            chk($sformatf("R2 R10 vec%0d hs_valid", k), 32'(hs_valid), 32'd1);
            chk($sformatf("R2 R5 R7 R8 vec%0d code", k), 32'(hs_code), 32'(VEC[k].code));
            chk($sformatf("R3 R4 vec%0d out_rdy", k), 32'(out_rdy), 32'(VEC[k].rdy));
            chk($sformatf("R2 R5 R6 vec%0d fill", k), 32'(fill), 32'(VEC[k].fill));
            @(negedge clk);
            chk($sformatf("R10 vec%0d idle", k), {30'd0, hs_valid, 1'b0} | 32'(hs_code), 32'd0);
        end

        // R9 setup path cleared data end earlier; check stall flag cleared too
        chk("R9 flags after setup", {30'd0, data_end, stall_on}, 32'd0);

        // R6 readback in order after a short packet
        cpu_act(3'd4);
        send_pkt(3, 8'hA0);
        chk("R3 short ready", 32'(out_rdy), 32'd1);
        for (int i = 0; i < 3; i++) begin
            chk($sformatf("R6 byte%0d", i), 32'(cpu_data), 32'(8'hA0 + 8'(i)));
            cpu_rd = 1'b1; @(negedge clk); cpu_rd = 1'b0;
        end

        // R8 forced stall wins over NAK while ready
        cpu_act(3'd3);
        chk("R8 stall flag", 32'(stall_on), 32'd1);
        send_pkt(5, 8'h10);
        chk("R8 stall over nak", 32'(hs_code), 32'(C_STALL));
        chk("R8 nothing stored", 32'(fill), 32'd3);

        // R9 bus reset clears everything
        usb_reset = 1'b1; @(negedge clk); usb_reset = 1'b0;
        chk("R9 reset flags", {29'd0, out_rdy, data_end, stall_on}, 32'd0);
        chk("R9 reset fill", 32'(fill), 32'd0);
        send_pkt(8, 8'h40);
        chk("R9 ack after reset", 32'(hs_code), 32'(C_ACK));

        // R6 clear ready empties buffer; R7 excess ACKed before data end
        send_pkt(1, 8'h55);
        chk("R6 ready before clear", 32'(out_rdy), 32'd1);
        cpu_act(3'd1);
        chk("R6 cleared ready", 32'(out_rdy), 32'd0);
        chk("R6 emptied", 32'(fill), 32'd0);
        send_pkt(8, 8'h60);
        chk("R7 excess acked", 32'(hs_code), 32'(C_ACK));
        cpu_act(3'd2);
        chk("R7 data end flag", 32'(data_end), 32'd1);
        send_pkt(8, 8'h70);
        chk("R7 stall after dend", 32'(hs_code), 32'(C_STALL));
        chk("R7 not stored", 32'(fill), 32'd8);
        chk("R10 none code const", 32'(C_NONE), 32'd0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule